// File: doc/BRIEF.md
# Toggle-Encoded Busy Link

This block moves a busy condition across a line that is AC-coupled and therefore cannot hold a steady level. The transmit half turns a level busy request into a line that keeps changing state for as long as busy is asserted. When busy is released, the line stays at whatever value it last had. The receive half watches several such lines. Each line goes through a synchroniser and an edge detector, and a per-channel idle timer turns the edge activity back into a level busy. The recovered busy flags of the enabled channels are combined into one stop-acquisition output that halts the whole detector.

The same outgoing line can also carry asynchronous triggers. A mode input bypasses the toggle generator and sends a registered copy of the trigger input to the line. In this mode the trigger is not encoded in any way.

Top module: `busy_toggle_link`

## Requirements
- R1: While reset is held and on the first cycle after it, fast_out, every busy_out bit and stop_acq are 0.
- R2: With trig_mode at 0 and busy_in at 1, fast_out changes value once every TOGGLE_DIV cycles. The first change is visible TOGGLE_DIV+1 clock edges after the first edge that samples busy_in high.
- R3: With trig_mode at 0 and busy_in at 0, fast_out keeps the value it last had. It does not fall back to 0.
- R4: Every new busy period starts its division count from zero. A partial count left over from the previous period does not shorten the first interval.
- R5: With trig_mode at 1, fast_out equals trig_in as sampled on the previous clock edge, and busy_in has no effect on fast_out.
- R6: A change on line_in[i] sets busy_out[i] on the third clock edge after the change. This is the SYNC_STAGES=2 case.
- R7: busy_out[i] stays at 1 while line_in[i] keeps changing at intervals no longer than TIMEOUT cycles. It falls exactly TIMEOUT clock edges after the last detected change.
- R8: stop_acq is 1 exactly one cycle after any channel has both busy_out[i] and ch_enable[i] at 1, and it is 0 one cycle after no such channel remains.
- R9: A channel whose ch_enable bit is 0 never raises stop_acq, even while its busy_out bit is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Machine clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| trig_mode | input | 1 | 1: outgoing line carries trig_in; 0: outgoing line carries toggle-encoded busy |
| busy_in | input | 1 | Level busy request to encode |
| trig_in | input | 1 | Asynchronous trigger to forward in trigger mode |
| fast_out | output | 1 | Outgoing line, registered |
| line_in | input | NUM_CH | Incoming toggle-encoded busy lines |
| ch_enable | input | NUM_CH | Per-channel enable for stop-acquisition |
| busy_out | output | NUM_CH | Recovered level busy per channel |
| stop_acq | output | 1 | Stop-acquisition to the whole detector |

## Verification
The bench builds the block with NUM_CH=3, TOGGLE_DIV=4, TIMEOUT=12 and SYNC_STAGES=2. A divide of 4 keeps the interval between toggles short enough that a busy burst of six cycles yields exactly one toggle plus a leftover partial count. That leftover makes the count restart in R4 visible on the line. A timeout of 12 lets a source that toggles every 8 cycles hold busy continuously, and lets the exact fall edge be observed after about a dozen cycles. Three channels with one of them disabled put the mask behaviour and the OR of the enabled channels in reach in the same run.

// File: rtl/busy_link_pkg.sv
package busy_link_pkg;

   typedef enum logic {
      LINK_BUSY = 1'b0,
      LINK_TRIG = 1'b1
   } link_mode_e;

   function automatic int cnt_bits(input int limit);
      return (limit < 2) ? 1 : $clog2(limit);
   endfunction

endpackage

// File: rtl/busy_toggle_tx.sv
module busy_toggle_tx #(
   parameter int TOGGLE_DIV = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic tog
);
   import busy_link_pkg::*;

   if (TOGGLE_DIV < 1) begin : g_bad_div
      $error("busy_toggle_tx: TOGGLE_DIV must be at least 1");
   end

   logic tog_q;

   if (TOGGLE_DIV == 1) begin : g_every_cycle
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)   tog_q <= 1'b0;
         else if (run) tog_q <= ~tog_q;
      end
   end else begin : g_divided
      localparam int CW = cnt_bits(TOGGLE_DIV);
      localparam logic [CW-1:0] LAST = CW'(TOGGLE_DIV - 1);
      logic [CW-1:0] div_cnt;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            div_cnt <= '0;
            tog_q   <= 1'b0;
         end else if (!run) begin
            div_cnt <= '0;
         end else if (div_cnt == LAST) begin
            div_cnt <= '0;
            tog_q   <= ~tog_q;
         end else begin
            div_cnt <= div_cnt + 1'b1;
         end
      end
   end

   assign tog = tog_q;

endmodule

// File: rtl/busy_toggle_rx.sv
module busy_toggle_rx #(
   parameter int TIMEOUT     = 12,
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_in,
   output logic busy
);
   import busy_link_pkg::*;

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("busy_toggle_rx: SYNC_STAGES must be at least 2");
   end
   if (TIMEOUT < 2) begin : g_bad_timeout
      $error("busy_toggle_rx: TIMEOUT must be at least 2");
   end

   localparam int CW = cnt_bits(TIMEOUT);
   localparam logic [CW-1:0] LAST = CW'(TIMEOUT - 1);

   logic [SYNC_STAGES:0] sh;
   logic                 seen_edge;
   logic                 busy_q;
   logic [CW-1:0]        idle_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh <= '0;
      else        sh <= {sh[SYNC_STAGES-1:0], line_in};
   end

   assign seen_edge = sh[SYNC_STAGES] ^ sh[SYNC_STAGES-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q   <= 1'b0;
         idle_cnt <= '0;
      end else if (seen_edge) begin
         busy_q   <= 1'b1;
         idle_cnt <= '0;
      end else if (busy_q) begin
         if (idle_cnt == LAST) begin
            busy_q   <= 1'b0;
            idle_cnt <= '0;
         end else begin
            idle_cnt <= idle_cnt + 1'b1;
         end
      end
   end

   assign busy = busy_q;

endmodule

// File: rtl/busy_toggle_link.sv
module busy_toggle_link #(
   parameter int NUM_CH      = 3,
   parameter int TOGGLE_DIV  = 4,
   parameter int TIMEOUT     = 12,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              trig_mode,
   input  logic              busy_in,
   input  logic              trig_in,
   output logic              fast_out,
   input  logic [NUM_CH-1:0] line_in,
   input  logic [NUM_CH-1:0] ch_enable,
   output logic [NUM_CH-1:0] busy_out,
   output logic              stop_acq
);
   import busy_link_pkg::*;

   if (NUM_CH < 1) begin : g_bad_ch
      $error("busy_toggle_link: NUM_CH must be at least 1");
   end
   if (TIMEOUT <= 2 * TOGGLE_DIV) begin : g_bad_ratio
      $error("busy_toggle_link: TIMEOUT must exceed twice TOGGLE_DIV");
   end

   link_mode_e        mode;
   logic              tx_run;
   logic              tog;
   logic              out_q;
   logic [NUM_CH-1:0] busy_vec;
   logic              stop_q;

   assign mode   = link_mode_e'(trig_mode);
   assign tx_run = busy_in && (mode == LINK_BUSY);

   busy_toggle_tx #(.TOGGLE_DIV(TOGGLE_DIV)) u_tx (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (tx_run),
      .tog   (tog)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  out_q <= 1'b0;
      else if (mode == LINK_TRIG)  out_q <= trig_in;
      else                         out_q <= tog;
   end

   for (genvar i = 0; i < NUM_CH; i++) begin : g_rx
      busy_toggle_rx #(
         .TIMEOUT     (TIMEOUT),
         .SYNC_STAGES (SYNC_STAGES)
      ) u_rx (
         .clk     (clk),
         .rst_n   (rst_n),
         .line_in (line_in[i]),
         .busy    (busy_vec[i])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stop_q <= 1'b0;
      else        stop_q <= |(busy_vec & ch_enable);
   end

   assign fast_out = out_q;
   assign busy_out = busy_vec;
   assign stop_acq = stop_q;

endmodule

// File: rtl/busy_toggle_link_chk.sv
module busy_toggle_link_chk #(
   parameter int NUM_CH = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              trig_mode,
   input logic              busy_in,
   input logic              trig_in,
   input logic              fast_out,
   input logic [NUM_CH-1:0] line_in,
   input logic [NUM_CH-1:0] ch_enable,
   input logic [NUM_CH-1:0] busy_out,
   input logic              stop_acq
);
   logic [2:0] since_rst;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                since_rst <= '0;
      else if (since_rst != 3'd7) since_rst <= since_rst + 1'b1;
   end

   AST_TRIG_COPY: assert property (@(posedge clk) disable iff (!rst_n)
      trig_mode |=> (fast_out == $past(trig_in))); // R5

   AST_TX_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
      (!trig_mode && $past(!trig_mode) && !busy_in && $past(!busy_in))
      |=> $stable(fast_out)); // R3

   AST_STOP_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (|(busy_out & ch_enable)) |=> stop_acq); // R8

   AST_STOP_MASK: assert property (@(posedge clk) disable iff (!rst_n)
      !(|(busy_out & ch_enable)) |=> !stop_acq); // R9

   for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      AST_RX_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
         ((since_rst > 3'd4) && $rose(busy_out[i]))
         |-> ($past(line_in[i], 3) != $past(line_in[i], 4))); // R6

      AST_RX_MIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(busy_out[i]) |=> busy_out[i]); // R7
   end

endmodule

bind busy_toggle_link busy_toggle_link_chk #(.NUM_CH(NUM_CH)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .trig_mode (trig_mode),
   .busy_in   (busy_in),
   .trig_in   (trig_in),
   .fast_out  (fast_out),
   .line_in   (line_in),
   .ch_enable (ch_enable),
   .busy_out  (busy_out),
   .stop_acq  (stop_acq)
);

// File: tb/sim_busy_toggle_link.sv
module sim_busy_toggle_link;

   localparam int NUM_CH = 3;
   localparam int DIV    = 4;
   localparam int TMO    = 12;

   typedef struct {
      int    cyc;
      int    sel;
      logic  val;
      string tag;
   } exp_t;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              trig_mode = 1'b0;
   logic              busy_in = 1'b0;
   logic              trig_in = 1'b0;
   logic              fast_out;
   logic [NUM_CH-1:0] line_in = '0;
   logic [NUM_CH-1:0] ch_enable = 3'b101;
   logic [NUM_CH-1:0] busy_out;
   logic              stop_acq;

   int   cyc = 0;
   int   total = 0;
   int   bad = 0;
   bit   done = 0;
   exp_t sb[$];

   always #4 clk = ~clk;

   busy_toggle_link #(
      .NUM_CH(NUM_CH), .TOGGLE_DIV(DIV), .TIMEOUT(TMO), .SYNC_STAGES(2)
   ) u0 (
      .clk(clk), .rst_n(rst_n), .trig_mode(trig_mode), .busy_in(busy_in),
      .trig_in(trig_in), .fast_out(fast_out), .line_in(line_in),
      .ch_enable(ch_enable), .busy_out(busy_out), .stop_acq(stop_acq)
   );

   function automatic logic pick(input int sel);
      if (sel == 0) return fast_out;
      if (sel == 1) return stop_acq;
      return busy_out[sel-2];
   endfunction

   // driver side: insert an expectation ordered by cycle
   task automatic expect_at(input int at, input int sel, input logic v, input string tag);
      exp_t e;
      int   idx;
      e.cyc = at; e.sel = sel; e.val = v; e.tag = tag;
      idx = sb.size();
      for (int k = 0; k < sb.size(); k++) begin
         if (sb[k].cyc > at) begin idx = k; break; end
      end
      sb.insert(idx, e);
   endtask

   task automatic report;
      if (!done) begin
         done = 1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   // monitor: after each edge, compare due expectations
   initial begin
      forever begin
         @(posedge clk);
         if (rst_n) cyc++;
         #2;
         while (sb.size() > 0 && sb[0].cyc <= cyc) begin
            exp_t e;
            logic got;
            e = sb.pop_front();
            got = pick(e.sel);
            total++;
            if (e.cyc < cyc || got !== e.val) begin
               bad++;
               $display("FAIL %s cyc=%0d sel=%0d actual=%b expected=%b",
                        e.tag, e.cyc, e.sel, got, e.val);
            end
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      report();
   end

   initial begin
      int c;
      repeat (3) @(negedge clk);
      // R1: all outputs low during reset
      total++;
      if (fast_out !== 1'b0 || stop_acq !== 1'b0 || busy_out !== '0) begin
         bad++;
         $display("FAIL R1 in reset actual=%b%b%b expected=00000", fast_out, stop_acq, busy_out);
      end
      rst_n = 1'b1;
      c = cyc;
      for (int s = 0; s < 2 + NUM_CH; s++) expect_at(c + 1, s, 1'b0, "R1");
      @(negedge clk);

      // R2: busy for six sampled edges -> one toggle at edge DIV, visible one later
      c = cyc;
      expect_at(c + DIV,     0, 1'b0, "R2");
      expect_at(c + DIV + 1, 0, 1'b1, "R2");
      busy_in = 1'b1;
      repeat (6) @(negedge clk);
      busy_in = 1'b0;
      // R3: frozen at 1 after busy drops
      expect_at(c + 12, 0, 1'b1, "R3");
      expect_at(c + 20, 0, 1'b1, "R3");
      repeat (19) @(negedge clk);

      // R4: new burst restarts the count; first toggle again DIV+1 edges later
      c = cyc;
      expect_at(c + 2,       0, 1'b1, "R4");
      expect_at(c + DIV,     0, 1'b1, "R4");
      expect_at(c + DIV + 1, 0, 1'b0, "R4");
      busy_in = 1'b1;
      repeat (5) @(negedge clk);
      busy_in = 1'b0;
      repeat (3) @(negedge clk);

      // R5: trigger pass-through, busy ignored
      c = cyc;
      trig_mode = 1'b1;
      busy_in   = 1'b1;
      trig_in   = 1'b1;
      expect_at(c + 1, 0, 1'b1, "R5");
      expect_at(c + 2, 0, 1'b0, "R5");
      expect_at(c + 3, 0, 1'b1, "R5");
      for (int k = 4; k <= 9; k++) expect_at(c + k, 0, 1'b0, "R5");
      @(negedge clk); trig_in = 1'b0;
      @(negedge clk); trig_in = 1'b1;
      @(negedge clk); trig_in = 1'b0;
      repeat (6) @(negedge clk);
      trig_mode = 1'b0;
      busy_in   = 1'b0;
      expect_at(cyc + 1, 0, 1'b0, "R3");
      repeat (3) @(negedge clk);

      // R6, R7, R9: masked channel 1
      c = cyc;
      line_in[1] = 1'b1;
      expect_at(c + 2, 3, 1'b0, "R6");
      expect_at(c + 3, 3, 1'b1, "R6");
      expect_at(c + 3 + TMO - 1, 3, 1'b1, "R7");
      expect_at(c + 3 + TMO,     3, 1'b0, "R7");
      for (int k = 4; k <= 16; k += 4) expect_at(c + k, 1, 1'b0, "R9");
      repeat (20) @(negedge clk);

      // R7, R8: enabled channel 0 toggling every 8 cycles
      c = cyc;
      expect_at(c + 3, 2, 1'b1, "R6");
      expect_at(c + 3, 1, 1'b0, "R8");
      expect_at(c + 4, 1, 1'b1, "R8");
      expect_at(c + 10, 2, 1'b1, "R7");
      expect_at(c + 18, 2, 1'b1, "R7");
      expect_at(c + 19 + TMO - 1, 2, 1'b1, "R7");
      expect_at(c + 19 + TMO,     2, 1'b0, "R7");
      expect_at(c + 19 + TMO,     1, 1'b1, "R8");
      expect_at(c + 20 + TMO,     1, 1'b0, "R8");
      for (int n = 0; n < 3; n++) begin
         line_in[0] = ~line_in[0];
         repeat (8) @(negedge clk);
      end
      repeat (20) @(negedge clk);

      wait (sb.size() == 0);
      @(negedge clk);
      report();
   end

endmodule